// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Sequencer

This block lives inside a controller for asynchronous DRAM. It decides when the memory needs a refresh, asks the controller's arbiter for the bus, and then drives the row strobe, column strobe, write strobe and address lines through one refresh cycle. Every duration is a parameter counted in clock cycles.

After reset the block stays silent for a power-up pause. It then runs a wake-up burst of refreshes and raises `init_done` when the burst is complete. From then on, an interval timer adds one pending refresh per period. Requests that cannot be served at once are counted up to a small cap. If the backlog goes unserved for too long, a deadline flag is raised, and the next grant replays the whole wake-up burst.

Two refresh styles are supported. In the first, the column strobe falls before the row strobe and the address lines are unused. In the second, only the row strobe moves, and an internal row counter drives the address lines. The style is chosen by `row_mode` and takes effect only when a refresh begins.

Top module: `dram_refresh_ctl`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are high, `addr` is 0, and `bus_req`, `init_done` and `deadline_missed` are low.
- R2: After reset is released, `bus_req` stays low for PAUSE_CYC cycles and is high in the cycle that follows.
- R3: The first WAKE_CNT refreshes after the pause form the wake-up burst. `init_done` is low while the last of them is under way, rises when it ends, and then stays high.
- R4: With `row_mode`=0 (column-first style), `cas_n` is low for exactly T_CSR cycles before `ras_n` falls and for exactly T_CHR cycles from the fall onward. `addr` is 0 and `we_n` is high throughout.
- R5: With `row_mode`=1 (row-only style), `cas_n` stays high. `addr` carries the row counter from one cycle before `ras_n` falls until `ras_n` rises, and `we_n` is high.
- R6: The row counter starts at 0, steps by one after each row-only refresh, and wraps from its all-ones value to 0. Column-first refreshes leave it unchanged.
- R7: Every refresh holds `ras_n` low for exactly T_RAS cycles. `ras_n` then stays high for at least max(T_RP, T_RPC) cycles. Strobes move only while `bus_req` and `bus_gnt` are both high, so no refresh happens while the grant is withheld.
- R8: Once `init_done` is high, one refresh becomes pending every INTERVAL_CYC cycles. The pending count saturates at PEND_MAX, and further periods are dropped. Each grant serves one pending refresh.
- R9: A period ends while refreshes are pending and none has started. When this happens for the MISS_LIMIT-th time, `deadline_missed` rises. The next refresh start clears the flag, discards the backlog and replays the WAKE_CNT-refresh burst.
- R10: `row_mode` is read only when a refresh starts. Changing it mid-refresh does not alter that refresh's strobe pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_mode | input | 1 | Refresh style: 0 column-first, 1 row-only with address |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| addr | output | ADDR_W | Row address in row-only style, 0 otherwise |
| init_done | output | 1 | Wake-up burst complete |
| deadline_missed | output | 1 | Refresh backlog overdue |

## Verification
The bench builds the block with a 20-cycle pause, a 40-cycle interval, a pending cap of 3, a miss limit of 4 periods and a 4-bit row counter. The strobe widths are short: a setup of 2 cycles, a hold of 2, a row strobe of 4 cycles low and a precharge of 3. These settings let a single run reach the end of the wake-up burst, pending saturation, a missed deadline followed by a replayed burst, and a full wrap of the row counter, all within a few thousand cycles. A port monitor measures every strobe edge and address value against the parameters, independently of the design.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_PRECH} phase_e;
  typedef enum logic {RF_CBR = 1'b0, RF_ROW = 1'b1} rfsh_kind_e;
endpackage

// File: rtl/rfsh_pacer.sv
module rfsh_pacer #(
  parameter int unsigned PAUSE_CYC    = 50000,
  parameter int unsigned INTERVAL_CYC = 3906
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pause_done,
  output logic tick
);
  localparam int unsigned TOP = (PAUSE_CYC > INTERVAL_CYC) ? PAUSE_CYC : INTERVAL_CYC;
  localparam int unsigned CW  = $clog2(TOP + 1);
  localparam logic [CW-1:0] PAUSE_LAST = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] IVL_LAST   = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    tick   = 1'b0;
    if (!done_q) begin
      if (cnt_q == PAUSE_LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (run) begin
      if (cnt_q == IVL_LAST) begin
        cnt_d = '0;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign pause_done = done_q;

  // R2: once the pause has ended it never restarts
  p_pause_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
endmodule

// File: rtl/rfsh_tracker.sv
module rfsh_tracker #(
  parameter int unsigned WAKE_CNT   = 8,
  parameter int unsigned PEND_MAX   = 4,
  parameter int unsigned MISS_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic tick,
  input  logic seq_idle,
  input  logic seq_done,
  input  logic gnt,
  output logic need,
  output logic start,
  output logic init_done,
  output logic missed
);
  localparam int unsigned WK_W = $clog2(WAKE_CNT + 1);
  localparam int unsigned PD_W = $clog2(PEND_MAX + 1);
  localparam int unsigned AG_W = $clog2(MISS_LIMIT + 1);
  localparam logic [WK_W-1:0] WAKE_FULL = WK_W'(WAKE_CNT);
  localparam logic [WK_W-1:0] WAKE_RELOAD = WK_W'(WAKE_CNT - 1);
  localparam logic [PD_W-1:0] PEND_CAP  = PD_W'(PEND_MAX);
  localparam logic [AG_W-1:0] AGE_LAST  = AG_W'(MISS_LIMIT - 1);

  logic [WK_W-1:0] wake_q, wake_d;
  logic [PD_W-1:0] pend_q, pend_d;
  logic [AG_W-1:0] age_q, age_d;
  logic            init_q, init_d, miss_q, miss_d;
  logic            consume;

  assign need    = pause_done && ((wake_q != '0) || (pend_q != '0) || miss_q);
  assign start   = need && gnt && seq_idle;
  assign consume = start && !miss_q && (wake_q == '0);

  always_comb begin
    wake_d = wake_q;
    pend_d = pend_q;
    age_d  = age_q;
    miss_d = miss_q;
    init_d = init_q;
    if (seq_done && (wake_q == '0)) init_d = 1'b1;
    // wake-up burst bookkeeping
    if (start && miss_q)              wake_d = WAKE_RELOAD;
    else if (start && wake_q != '0)   wake_d = wake_q - 1'b1;
    // pending count, saturating
    if (start && miss_q)                               pend_d = '0;
    else if (tick && !consume && pend_q != PEND_CAP)   pend_d = pend_q + 1'b1;
    else if (consume && !tick)                         pend_d = pend_q - 1'b1;
    // deadline ageing
    if (start) begin
      age_d  = '0;
      miss_d = 1'b0;
    end else if (tick && pend_q != '0 && !miss_q) begin
      if (age_q == AGE_LAST) miss_d = 1'b1;
      else                   age_d  = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= WAKE_FULL;
      pend_q <= '0;
      age_q  <= '0;
      init_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      wake_q <= wake_d;
      pend_q <= pend_d;
      age_q  <= age_d;
      init_q <= init_d;
      miss_q <= miss_d;
    end
  end

  assign init_done = init_q;
  assign missed    = miss_q;

  p_pend_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_CAP);
  p_miss_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && miss_q) |=> (!miss_q && wake_q == WAKE_RELOAD && pend_q == '0));
  p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> init_q);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import refresh_pkg::*;
#(
  parameter int unsigned T_CSR  = 3,
  parameter int unsigned T_CHR  = 3,
  parameter int unsigned T_RAS  = 15,
  parameter int unsigned T_PRE  = 10,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              row_mode,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              idle,
  output logic              done
);
  localparam int unsigned TA   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int unsigned TOPL = (TA > T_PRE) ? TA : T_PRE;
  localparam int unsigned CW   = $clog2(TOPL + 1);

  phase_e            ph_q, ph_d;
  rfsh_kind_e        kind_q, kind_d;
  logic [CW-1:0]     cnt_q, cnt_d, last;
  logic [ADDR_W-1:0] row_q, row_d;

  always_comb begin
    case (ph_q)
      PH_SETUP:  last = (kind_q == RF_CBR) ? CW'(T_CSR - 1) : '0;
      PH_ACTIVE: last = CW'(T_RAS - 1);
      PH_PRECH:  last = CW'(T_PRE - 1);
      default:   last = '0;
    endcase
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    row_d  = row_q;
    done   = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_d   = PH_SETUP;
        cnt_d  = '0;
        kind_d = row_mode ? RF_ROW : RF_CBR;
      end
    end else if (cnt_q == last) begin
      cnt_d = '0;
      case (ph_q)
        PH_SETUP:  ph_d = PH_ACTIVE;
        PH_ACTIVE: begin
          ph_d = PH_PRECH;
          if (kind_q == RF_ROW) row_d = row_q + 1'b1;
        end
        default: begin
          ph_d = PH_IDLE;
          done = 1'b1;
        end
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= RF_CBR;
      row_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      row_q  <= row_d;
    end
  end

  assign idle  = (ph_q == PH_IDLE);
  assign ras_n = (ph_q != PH_ACTIVE);
  assign cas_n = !((kind_q == RF_CBR) &&
                   ((ph_q == PH_SETUP) || (ph_q == PH_ACTIVE && cnt_q < CW'(T_CHR))));
  assign addr  = (kind_q == RF_ROW && (ph_q == PH_SETUP || ph_q == PH_ACTIVE)) ? row_q : '0;
  assign we_n  = 1'b1;

  // checker-only run length of the low row strobe
  logic [CW-1:0] lo_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lo_q <= '0;
    else if (ras_n)               lo_q <= '0;
    else if (lo_q != CW'(TOPL))   lo_q <= lo_q + 1'b1;
  end

  p_cas_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && kind_q == RF_CBR) |-> (!cas_n && $past(!cas_n)));
  p_row_cas_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == RF_ROW) |-> cas_n);
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$fell(ras_n)) |-> $stable(addr));
  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_q) |-> (row_q == $past(row_q) + 1'b1));
  p_ras_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_q == CW'(T_RAS)));
  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(kind_q));
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl #(
  parameter int unsigned PAUSE_CYC    = 50000,
  parameter int unsigned INTERVAL_CYC = 3906,
  parameter int unsigned WAKE_CNT     = 8,
  parameter int unsigned T_CSR        = 3,
  parameter int unsigned T_CHR        = 3,
  parameter int unsigned T_RAS        = 15,
  parameter int unsigned T_RP         = 10,
  parameter int unsigned T_RPC        = 2,
  parameter int unsigned PEND_MAX     = 4,
  parameter int unsigned MISS_LIMIT   = 8,
  parameter int unsigned ADDR_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_mode,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              deadline_missed
);
  localparam int unsigned T_PRE = (T_RP > T_RPC) ? T_RP : T_RPC;

  logic pause_done, tick, need, start, seq_idle, seq_done;

  rfsh_pacer #(.PAUSE_CYC(PAUSE_CYC), .INTERVAL_CYC(INTERVAL_CYC)) pacer_i (
    .clk(clk), .rst_n(rst_n), .run(init_done),
    .pause_done(pause_done), .tick(tick));

  rfsh_tracker #(.WAKE_CNT(WAKE_CNT), .PEND_MAX(PEND_MAX), .MISS_LIMIT(MISS_LIMIT)) tracker_i (
    .clk(clk), .rst_n(rst_n), .pause_done(pause_done), .tick(tick),
    .seq_idle(seq_idle), .seq_done(seq_done), .gnt(bus_gnt),
    .need(need), .start(start), .init_done(init_done), .missed(deadline_missed));

  rfsh_seq #(.T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_PRE(T_PRE), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .row_mode(row_mode),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .idle(seq_idle), .done(seq_done));

  assign bus_req = need || !seq_idle;

  p_strobe_on_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> (bus_req && bus_gnt));
  p_quiet_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> !bus_req);
  p_no_start_unready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !deadline_missed);
endmodule

// File: tb/dram_refresh_ctl_tb_top.sv
module dram_refresh_ctl_tb_top;
  localparam int PAUSE = 20, IVL = 40, WAKE = 8;
  localparam int TCSR = 2, TCHR = 2, TRAS = 4, TRP = 3, TRPC = 2;
  localparam int PMAX = 3, MLIM = 4, AW = 4;
  localparam int ROWS = 1 << AW;

  typedef struct packed {
    logic       mode;
    logic [3:0] hold;
    logic [3:0] cnt;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 4'd0, 4'd1}, '{1'b1, 4'd0, 4'd1}, '{1'b0, 4'd3, 4'd3},
    '{1'b1, 4'd4, 4'd3}, '{1'b1, 4'd2, 4'd2}, '{1'b0, 4'd0, 4'd1}};

  logic clk = 1'b0, rst_n = 1'b0, row_mode = 1'b0, gnt_en = 1'b1;
  logic bus_req, bus_gnt, ras_n, cas_n, we_n, init_done, deadline_missed;
  logic [AW-1:0] addr;
  assign bus_gnt = bus_req & gnt_en;

  dram_refresh_ctl #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVL), .WAKE_CNT(WAKE),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP), .T_RPC(TRPC),
    .PEND_MAX(PMAX), .MISS_LIMIT(MLIM), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_mode(row_mode), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .init_done(init_done), .deadline_missed(deadline_missed));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, mchecks = 0, mfails = 0;
  int nfalls = 0, cbr_n = 0, ro_n = 0, exp_row = 0;
  bit wrap_seen = 0;
  int t0 = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string rq, input int act, input int exp);
    mchecks++;
    if (!ok) begin
      mfails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // port monitor: measures every refresh against the parameters
  bit prev_ras = 1, cur_cbr = 0, started = 0;
  int lo_len = 0, hi_len = 0, pre_cas = 0, in_cas = 0, prev_addr = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1; lo_len = 0; hi_len = 0; pre_cas = 0; in_cas = 0; started = 0;
    end else begin
      if (!ras_n || !cas_n) mchk(bus_gnt, "R7 strobe without grant", bus_gnt, 1);
      if (prev_ras && !ras_n) begin
        nfalls++;
        cur_cbr = !cas_n;
        if (started) mchk(hi_len >= TRP, "R7 precharge cycles", hi_len, TRP);
        mchk(we_n, "R4 R5 we_n high at row strobe", we_n, 1);
        if (cur_cbr) begin
          cbr_n++;
          mchk(pre_cas == TCSR, "R4 cas lead cycles", pre_cas, TCSR);
          mchk(addr == 0, "R4 address zero", int'(addr), 0);
        end else begin
          ro_n++;
          mchk(int'(addr) == exp_row, "R5 row address at fall", int'(addr), exp_row);
          mchk(prev_addr == exp_row, "R5 row address setup", prev_addr, exp_row);
        end
        lo_len = 1; in_cas = cas_n ? 0 : 1; started = 1;
      end else if (!ras_n) begin
        lo_len++;
        if (!cas_n) in_cas++;
        if (!cur_cbr) begin
          mchk(cas_n, "R5 cas high", cas_n, 1);
          mchk(int'(addr) == exp_row, "R5 row address hold", int'(addr), exp_row);
        end
      end else if (!prev_ras && ras_n) begin
        mchk(lo_len == TRAS, "R7 row strobe width", lo_len, TRAS);
        if (cur_cbr) mchk(in_cas == TCHR, "R4 cas hold cycles", in_cas, TCHR);
        else begin
          if (exp_row == ROWS - 1) wrap_seen = 1;
          exp_row = (exp_row + 1) % ROWS;
        end
        hi_len = 1; pre_cas = cas_n ? 0 : 1;
      end else begin
        hi_len++;
        if (!cas_n) pre_cas++; else pre_cas = 0;
      end
      prev_ras = ras_n;
      prev_addr = int'(addr);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_at(input int n, input int off);
    while (cyc < t0 + IVL * n + off) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mchecks + 1, fails + mfails + 1);
    $finish;
  end

  initial begin
    int n;
    int bc, br, bf, k;
    bit early;
    repeat (3) step();
    // R1 reset state
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!bus_req, "R1 no request in reset", bus_req, 0);
    chk(!init_done && !deadline_missed, "R1 flags low in reset", {init_done, deadline_missed}, 0);
    chk(addr == 0, "R1 address zero in reset", int'(addr), 0);
    rst_n = 1'b1;
    // R2 power-up pause
    early = 0;
    for (int i = 0; i < PAUSE - 1; i++) begin step(); if (bus_req) early = 1; end
    chk(!early, "R2 silent during pause", early, 0);
    step();
    chk(bus_req, "R2 request after pause", bus_req, 1);
    // R3 wake-up burst
    while (nfalls < WAKE) step();
    chk(!init_done, "R3 init_done low during last burst refresh", init_done, 0);
    k = 0;
    while (!init_done && k < 20) begin step(); k++; end
    chk(init_done, "R3 init_done after burst", init_done, 1);
    chk(cbr_n == WAKE, "R3 burst refresh count", cbr_n, WAKE);
    t0 = cyc;
    n = 0;
    // R8 vectors: mode, periods without grant, refreshes expected after release
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v = VECS[i];
      wait_at(n, 38);
      row_mode = v.mode;
      bc = cbr_n; br = ro_n;
      if (v.hold == 0) begin
        gnt_en = 1'b1;
        n++;
      end else begin
        gnt_en = 1'b0;
        n += int'(v.hold);
        wait_at(n, 5);
        chk(cbr_n == bc && ro_n == br, "R7 no refresh while grant withheld", cbr_n + ro_n - bc - br, 0);
        gnt_en = 1'b1;
      end
      wait_at(n, 38);
      if (v.mode) chk(ro_n - br == int'(v.cnt) && cbr_n == bc, "R8 row-only refresh count", ro_n - br, int'(v.cnt));
      else        chk(cbr_n - bc == int'(v.cnt) && ro_n == br, "R8 column-first refresh count", cbr_n - bc, int'(v.cnt));
      chk(!deadline_missed, "R8 no deadline miss", deadline_missed, 0);
    end
    // R10 mode change during a refresh
    row_mode = 1'b0;
    bc = cbr_n; br = ro_n;
    n++;
    wait_at(n, 3);
    row_mode = 1'b1;
    wait_at(n, 38);
    chk(cbr_n - bc == 1 && ro_n == br, "R10 running refresh keeps its style", cbr_n - bc, 1);
    br = ro_n;
    n++;
    wait_at(n, 38);
    chk(ro_n - br == 1, "R10 new style at next start", ro_n - br, 1);
    // R6 row counter wrap
    br = ro_n;
    n += 17;
    wait_at(n, 38);
    chk(ro_n - br == 17, "R6 row-only refreshes", ro_n - br, 17);
    chk(wrap_seen, "R6 row counter wrapped to zero", wrap_seen, 1);
    // R9 missed deadline and replayed burst
    row_mode = 1'b0;
    gnt_en = 1'b0;
    n += 4;
    wait_at(n, 5);
    chk(!deadline_missed, "R9 flag low before limit", deadline_missed, 0);
    n++;
    wait_at(n, 5);
    chk(deadline_missed, "R9 flag set at limit", deadline_missed, 1);
    bf = nfalls;
    gnt_en = 1'b1;
    wait_at(n, 8);
    chk(!deadline_missed, "R9 flag cleared by grant", deadline_missed, 0);
    wait_at(n, 84);
    chk(nfalls - bf == WAKE, "R9 replayed burst length", nfalls - bf, WAKE);
    chk(init_done, "R3 init_done stays high", init_done, 1);
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mchecks, fails + mfails);
    $finish;
  end
endmodule